// File: doc/BRIEF.md
# Flash Write-Protection Gate

This block sits in front of a paged flash array and decides, command by command, whether a write, a page erase or a mass erase may reach the flash. User space is split into 32 equal groups of pages. One bit of a 32-bit lock word guards each group, and a bit at 0 means the group is locked. Software can lock more groups at run time, but only after it has written a fixed unlock key. A power-on preload strobe supplies the initial lock word. Locks are removed only by reset, by a completed mass erase, or by a completed erase of the top user page.

Commands arrive on a valid/ready stream and leave towards the flash on a second valid/ready stream. The flash reports back on two plain pulses: one when it begins a command and one when it completes it. An abort command cancels the command in flight. When the cancelled command was a write that the flash had already begun, its target address is kept for software to read.

Top module: `flash_wprot_unit`

## Requirements
- R1: After reset the lock word reads 0xFFFFFFFF and `cmd_ready` stays low. The first `preload_valid` pulse loads `preload_word` into the lock word and opens the command port. Later preload pulses are ignored.
- R2: Register select codes are 0 = key, 1 = lock word, 2 = abort address, 3 = status. A lock-word write takes effect only when the most recent key write carried 0x676C7565 and that key has not yet been consumed. The key register always reads 0.
- R3: An effective lock-word write ANDs the written data into the word. Written 0s lock groups. Written 1s change nothing, so software can never unlock a group.
- R4: A lock-word write without a valid key is dropped and sets the sticky key-error flag, which is status bit 0. Writing status with bit 0 set clears the flag.
- R5: A valid key is consumed by one lock-word write or by one accepted mass erase. After that, a further lock-word write is dropped.
- R6: Command op codes are 0 = write, 1 = page erase, 2 = mass erase, 3 = abort. For writes and page erases, the lock bit is chosen by byte address divided by (user size / 32), so bit 31 covers the top group. A write or page erase that targets a locked group is rejected. Rejection gives a one-cycle `cmd_reject` pulse in the cycle after the handshake, and nothing is forwarded.
- R7: A write or page erase whose address is at or above the end of user space (0x40000 by default) is always rejected.
- R8: A mass erase is rejected unless a valid key is present. When an accepted mass erase completes (`fl_done`), the lock word returns to 0xFFFFFFFF.
- R9: An erase of the top user page is subject to bit 31. When it completes, the lock word returns to 0xFFFFFFFF. A completed erase of any other page leaves the lock word unchanged.
- R10: An abort given after `fl_start` of a write stores that write's address in the abort-address register. An abort given before `fl_start` leaves the register unchanged. Any abort of a command in flight raises `fl_abort` for one cycle.
- R11: `cmd_ready` is high once preloaded, when no command is in flight, or when the offered op is abort. An accepted command appears on `fwd_valid`, `fwd_op` and `fwd_addr` in the next cycle, and these are held steady until `fwd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| preload_valid | input | 1 | Power-on lock-word load strobe |
| preload_word | input | 32 | Lock word to preload |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_sel` (combinational) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle |
| cmd_op | input | 2 | Command op code |
| cmd_addr | input | 20 | Command byte address |
| cmd_reject | output | 1 | One-cycle rejection pulse |
| fwd_valid | output | 1 | Command offered to flash |
| fwd_ready | input | 1 | Flash takes the command |
| fwd_op | output | 2 | Forwarded op code |
| fwd_addr | output | 20 | Forwarded address |
| fl_start | input | 1 | Flash began the taken command |
| fl_done | input | 1 | Flash completed the command |
| fl_abort | output | 1 | Abort pulse towards flash |

## Verification
The bench probes the first and last byte of every group against a lock word with both end groups locked. A wrong group shift or an off-by-one range compare shows up as a flipped accept/reject at a boundary. It tries to set lock bits back to 1, to write without a key, and to reuse a consumed key. A design that ORed the data, or that kept the key alive, would then read back an unlocked group. It compares an erase of the top page with an erase of its neighbour in the same group, and mass erase with and without a key, catching a design that unlocks on the wrong page or without the key. Aborts before and after the flash begins a write show whether the abort address is latched only once the write has really started.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_PERASE = 2'd1,
    OP_MERASE = 2'd2,
    OP_ABORT  = 2'd3
  } fwp_op_e;

  typedef enum logic [1:0] {
    SEL_KEY   = 2'd0,
    SEL_LOCK  = 2'd1,
    SEL_ABORT = 2'd2,
    SEL_STAT  = 2'd3
  } fwp_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } fwp_state_e;

  localparam logic [31:0] UNLOCK_KEY = 32'h676C7565;
  localparam int unsigned NUM_GROUPS = 32;
endpackage

// File: rtl/fwp_addr_map.sv
module fwp_addr_map #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned NUM_PAGES  = 128
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [4:0]        grp,
  output logic              in_user,
  output logic              is_top
);
  localparam int unsigned USER_BYTES  = PAGE_BYTES * NUM_PAGES;
  localparam int unsigned GROUP_BYTES = USER_BYTES / fwp_pkg::NUM_GROUPS;
  localparam int unsigned GSH         = $clog2(GROUP_BYTES);
  localparam logic [ADDR_W-1:0] USER_END = ADDR_W'(USER_BYTES);
  localparam logic [ADDR_W-1:0] TOP_BASE = ADDR_W'(USER_BYTES - PAGE_BYTES);

  generate
    if (ADDR_W > GSH + 5) begin : g_wide
      assign grp = addr[GSH+4:GSH];
    end else begin : g_exact
      assign grp = addr[ADDR_W-1 -: 5];
    end
  endgenerate

  assign in_user = addr < USER_END;
  assign is_top  = in_user && (addr >= TOP_BASE);
endmodule

// File: rtl/fwp_regs.sv
module fwp_regs
  import fwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preload_valid,
  input  logic [31:0] preload_word,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        restore,
  input  logic        merase_take,
  output logic [31:0] lock_word,
  output logic        key_ok,
  output logic        key_err,
  output logic        loaded
);
  logic wr_key, wr_lock, wr_stat, pre_fire;

  assign wr_key   = reg_wr && (fwp_sel_e'(reg_sel) == SEL_KEY);
  assign wr_lock  = reg_wr && (fwp_sel_e'(reg_sel) == SEL_LOCK);
  assign wr_stat  = reg_wr && (fwp_sel_e'(reg_sel) == SEL_STAT);
  assign pre_fire = preload_valid && !loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_word <= '1;
      loaded    <= 1'b0;
    end else if (pre_fire) begin
      lock_word <= preload_word;
      loaded    <= 1'b1;
    end else if (restore) begin
      lock_word <= '1;
    end else if (wr_lock && key_ok) begin
      lock_word <= lock_word & reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   key_ok <= 1'b0;
    else if (wr_key)              key_ok <= (reg_wdata == UNLOCK_KEY);
    else if (wr_lock || merase_take) key_ok <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      key_err <= 1'b0;
    else if (wr_lock && !key_ok)     key_err <= 1'b1;
    else if (wr_stat && reg_wdata[0]) key_err <= 1'b0;
  end

  AST_LOCK_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && !pre_fire) |=> ((lock_word & ~$past(lock_word)) == '0)); // R3
  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock || merase_take) && !wr_key |=> !key_ok); // R5
endmodule

// File: rtl/fwp_cmd_seq.sv
module fwp_cmd_seq
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              cmd_reject,
  input  logic              loaded,
  input  logic [31:0]       lock_word,
  input  logic              key_ok,
  input  logic [4:0]        grp,
  input  logic              in_user,
  input  logic              is_top,
  output logic              fwd_valid,
  output logic [1:0]        fwd_op,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              fwd_ready,
  input  logic              fl_start,
  input  logic              fl_done,
  output logic              fl_abort,
  output logic              restore,
  output logic              merase_take,
  output logic [ADDR_W-1:0] abort_addr
);
  fwp_state_e        state;
  fwp_op_e           op_in, cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_top;
  logic              hs, is_abort, bad, abort_latch;

  assign op_in     = fwp_op_e'(cmd_op);
  assign cmd_ready = loaded && ((state == ST_IDLE) || (op_in == OP_ABORT));
  assign hs        = cmd_valid && cmd_ready;
  assign is_abort  = (op_in == OP_ABORT);

  always_comb begin
    case (op_in)
      OP_WRITE, OP_PERASE: bad = !in_user || !lock_word[grp];
      OP_MERASE:           bad = !key_ok;
      default:             bad = 1'b0;
    endcase
  end

  assign abort_latch = hs && is_abort && (state == ST_RUN) && (cur_op == OP_WRITE);
  assign merase_take = hs && (op_in == OP_MERASE) && !bad;
  assign restore     = (state == ST_RUN) && fl_done && !(hs && is_abort) &&
                       ((cur_op == OP_MERASE) || ((cur_op == OP_PERASE) && cur_top));

  assign fwd_valid = (state == ST_FWD);
  assign fwd_op    = cur_op;
  assign fwd_addr  = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_op     <= OP_WRITE;
      cur_addr   <= '0;
      cur_top    <= 1'b0;
      abort_addr <= '0;
      cmd_reject <= 1'b0;
      fl_abort   <= 1'b0;
    end else begin
      cmd_reject <= hs && !is_abort && bad;
      fl_abort   <= hs && is_abort && (state != ST_IDLE);
      if (hs && is_abort) begin
        if (abort_latch) abort_addr <= cur_addr;
        state <= ST_IDLE;
      end else if (hs && !bad) begin
        cur_op   <= op_in;
        cur_addr <= cmd_addr;
        cur_top  <= is_top;
        state    <= ST_FWD;
      end else begin
        case (state)
          ST_FWD:  if (fwd_ready) state <= ST_WAIT;
          ST_WAIT: if (fl_start)  state <= ST_RUN;
          ST_RUN:  if (fl_done)   state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_REJECT_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> !fwd_valid); // R6
  AST_FWD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready && !(cmd_valid && is_abort) |=>
      fwd_valid && $stable(fwd_addr) && $stable(fwd_op)); // R11
  AST_ABORT_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_latch |=> $stable(abort_addr)); // R10
endmodule

// File: rtl/flash_wprot_unit.sv
module flash_wprot_unit
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned NUM_PAGES  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preload_valid,
  input  logic [31:0]       preload_word,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_reject,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [1:0]        fwd_op,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              fl_start,
  input  logic              fl_done,
  output logic              fl_abort
);
  logic [31:0]       lock_word;
  logic              key_ok, key_err, loaded, restore, merase_take;
  logic [4:0]        grp;
  logic              in_user, is_top;
  logic [ADDR_W-1:0] abort_addr;

  fwp_addr_map #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_map (
    .addr(cmd_addr), .grp(grp), .in_user(in_user), .is_top(is_top));

  fwp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .preload_valid(preload_valid), .preload_word(preload_word),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .restore(restore),
    .merase_take(merase_take), .lock_word(lock_word), .key_ok(key_ok),
    .key_err(key_err), .loaded(loaded));

  fwp_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .cmd_reject(cmd_reject), .loaded(loaded), .lock_word(lock_word),
    .key_ok(key_ok), .grp(grp), .in_user(in_user), .is_top(is_top),
    .fwd_valid(fwd_valid), .fwd_op(fwd_op), .fwd_addr(fwd_addr), .fwd_ready(fwd_ready),
    .fl_start(fl_start), .fl_done(fl_done), .fl_abort(fl_abort), .restore(restore),
    .merase_take(merase_take), .abort_addr(abort_addr));

  always_comb begin
    case (fwp_sel_e'(reg_sel))
      SEL_LOCK:  reg_rdata = lock_word;
      SEL_ABORT: reg_rdata = 32'(abort_addr);
      SEL_STAT:  reg_rdata = {31'd0, key_err};
      default:   reg_rdata = 32'd0;
    endcase
  end

  AST_CLOSED_UNTIL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !cmd_ready); // R1
endmodule

// File: tb/flash_wprot_unit_bench.sv
`timescale 1ns/1ps
module flash_wprot_unit_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        preload_valid = 1'b0;
  logic [31:0] preload_word = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [19:0] cmd_addr = '0;
  logic        cmd_reject, fwd_valid, fl_abort;
  logic        fwd_ready = 1'b0, fl_start = 1'b0, fl_done = 1'b0;
  logic [1:0]  fwd_op;
  logic [19:0] fwd_addr;
  int checks = 0, failures = 0;
  localparam logic [31:0] KEY = 32'h676C7565;

  always #5 clk = ~clk;

  flash_wprot_unit u_flash_wprot_unit (.*);

  // {op, addr, expect_accept} with lock word 0x7FFFFFFE
  localparam logic [22:0] VEC [10] = '{
    {2'd0, 20'h00000, 1'b0}, {2'd0, 20'h01FFF, 1'b0}, {2'd0, 20'h02000, 1'b1},
    {2'd1, 20'h3E000, 1'b0}, {2'd1, 20'h3DFFF, 1'b1}, {2'd0, 20'h3C000, 1'b1},
    {2'd0, 20'h40000, 1'b0}, {2'd1, 20'hFFFFF, 1'b0}, {2'd2, 20'h00000, 1'b0},
    {2'd1, 20'h20800, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  // offer one command; afterwards we sit at the negedge following the handshake
  task automatic send(input logic [1:0] op, input logic [19:0] a, output logic acc);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk); cmd_valid = 1'b0;
    acc = fwd_valid && !cmd_reject;
  endtask

  task automatic finish_cmd();
    fwd_ready = 1'b1; @(negedge clk); fwd_ready = 1'b0;
    fl_start = 1'b1;  @(negedge clk); fl_start = 1'b0;
    fl_done = 1'b1;   @(negedge clk); fl_done = 1'b0;
  endtask

  task automatic set_lock(input logic [31:0] w);
    reg_write(2'd0, KEY); reg_write(2'd1, w);
  endtask

  task automatic mass_erase();
    logic a;
    reg_write(2'd0, KEY); send(2'd2, 20'h0, a);
    if (a) finish_cmd();
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and preload
    reg_read(2'd1, d); chk("R1 reset lock word", d, 32'hFFFFFFFF);
    cmd_valid = 1'b1; cmd_op = 2'd0; #1 chk("R1 ready low before preload", 32'(cmd_ready), 0);
    cmd_valid = 1'b0;
    reg_read(2'd0, d); chk("R2 key reads zero", d, 0);
    @(negedge clk); preload_valid = 1'b1; preload_word = 32'hFFFF0FFF;
    @(negedge clk); preload_valid = 1'b0;
    reg_read(2'd1, d); chk("R1 preload loaded", d, 32'hFFFF0FFF);
    @(negedge clk); preload_valid = 1'b1; preload_word = 32'h0;
    @(negedge clk); preload_valid = 1'b0;
    reg_read(2'd1, d); chk("R1 second preload ignored", d, 32'hFFFF0FFF);
    // R8 mass erase key rule and restore
    send(2'd2, 20'h0, a); chk("R8 mass erase without key rejected", 32'(cmd_reject), 1);
    @(negedge clk); chk("R6 reject pulse one cycle", 32'(cmd_reject), 0);
    mass_erase();
    reg_read(2'd1, d); chk("R8 mass erase restores", d, 32'hFFFFFFFF);
    // R5 key consumed by mass erase; R4 key error
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, d); chk("R5 spent key drops write", d, 32'hFFFFFFFF);
    reg_read(2'd3, d); chk("R4 key error set", d, 1);
    reg_write(2'd3, 32'h0);
    reg_read(2'd3, d); chk("R4 writing 0 keeps flag", d, 1);
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, d); chk("R4 flag cleared", d, 0);
    // R2/R3 keyed AND
    set_lock(32'h7FFFFFFE);
    reg_read(2'd1, d); chk("R2 keyed write applied", d, 32'h7FFFFFFE);
    reg_read(2'd0, d); chk("R2 key reads zero after write", d, 0);
    set_lock(32'hFFFFFFFF);
    reg_read(2'd1, d); chk("R3 ones do not unlock", d, 32'h7FFFFFFE);
    reg_write(2'd0, 32'h676C7564); reg_write(2'd1, 32'h0);
    reg_read(2'd1, d); chk("R2 wrong key dropped", d, 32'h7FFFFFFE);
    reg_write(2'd0, KEY); reg_write(2'd1, 32'hFFFFFFFF); reg_write(2'd1, 32'h0);
    reg_read(2'd1, d); chk("R5 key used once", d, 32'h7FFFFFFE);
    reg_write(2'd3, 32'h1);
    // R6/R7 vector table
    foreach (VEC[i]) begin
      send(VEC[i][22:21], VEC[i][20:1], a);
      chk($sformatf("R6 R7 vector %0d", i), 32'(a), 32'(VEC[i][0]));
      if (a) finish_cmd();
    end
    // R6 every group boundary
    for (int g = 0; g < 32; g++) begin
      for (int e = 0; e < 2; e++) begin
        send(2'd0, 20'(g * 32'h2000 + e * 32'h1FFF), a);
        chk($sformatf("R6 group %0d edge %0d", g, e), 32'(a), 32'(g != 0 && g != 31));
        if (a) finish_cmd();
      end
    end
    // R9 top page
    send(2'd1, 20'h3F800, a); chk("R9 locked top page rejected", 32'(a), 0);
    mass_erase();
    set_lock(32'hFFFFFFF0);
    send(2'd1, 20'h3E000, a); chk("R9 neighbour page accepted", 32'(a), 1);
    finish_cmd();
    reg_read(2'd1, d); chk("R9 neighbour erase keeps locks", d, 32'hFFFFFFF0);
    send(2'd1, 20'h3F800, a); chk("R9 top page accepted", 32'(a), 1);
    finish_cmd();
    reg_read(2'd1, d); chk("R9 top erase restores", d, 32'hFFFFFFFF);
    // R10/R11 abort and forward hold
    send(2'd0, 20'h12340, a);
    chk("R11 ready low while busy", 32'(cmd_ready), 0);
    @(negedge clk); @(negedge clk);
    chk("R11 fwd held", {11'd0, fwd_valid, fwd_addr}, {11'd0, 1'b1, 20'h12340});
    fwd_ready = 1'b1; @(negedge clk); fwd_ready = 1'b0;
    fl_start = 1'b1;  @(negedge clk); fl_start = 1'b0;
    send(2'd3, 20'h0, a);
    chk("R10 abort pulse", 32'(fl_abort), 1);
    reg_read(2'd2, d); chk("R10 started write latched", d, 32'h12340);
    send(2'd0, 20'h05000, a);
    send(2'd3, 20'h0, a);
    reg_read(2'd2, d); chk("R10 early abort keeps address", d, 32'h12340);
    chk("R10 idle after abort", 32'(fwd_valid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule